// File: doc/BRIEF.md
# Serial ADC Command Front End

This block is the digital side of a sampling converter's host port. A host sends 16-bit command frames over a four-wire serial link: an active-low chip select, a serial clock, a data input and a data output. The host can also mark frame starts with a falling edge on a frame-sync pin while chip select stays low. The top four bits of each frame are a command. The command can pick an input channel, write a 12-bit configuration word, or ask for the configuration to be returned. While the host shifts a command in, the data output shifts out the last conversion result.

Sampling of the picked channel can begin in one of two ways. It can begin by itself once the command is known, or it can follow an external active-low start pin. A stand-in converter then finishes after a fixed number of conversion clocks. Those clocks come from an internal divided oscillator or from the serial clock, chosen by a configuration bit. When the result is ready, an active-low interrupt output falls. All pins are taken as synchronous to `clk`. Edges are seen at the first `clk` rising edge where the new level is present.

Top module: `adc_cmd_frontend`

## Requirements
- R1: A frame is shifted in MSB first, one bit per detected `sclk` rising edge while `cs_n` is low. When the frame's nibble is 4'hA, the other 12 bits are copied to `cfg` on the 16th edge.
- R2: After 16 edges, further `sclk` edges are ignored until a new frame start, which is a `cs_n` or `fs_n` falling edge.
- R3: A `cs_n` rising edge before the 16th edge closes the frame, and a partial write frame leaves `cfg` unchanged.
- R4: An `fs_n` falling edge while `cs_n` stays low clears the edge count and starts a new frame.
- R5: Nibbles 4'h0 to 4'h3 select channel nibble[1:0], shown on `chan` from the 4th edge. When `cstart_n` is high, `sampling` rises at that same edge.
- R6: In normal mode the conversion starts at frame close, either the 16th edge or an early `cs_n` rise, and `sampling` falls there.
- R7: While `cstart_n` is low, `sampling` is high and frame close starts no conversion. A `cstart_n` rising edge starts one conversion.
- R8: Frames whose nibble is not 4'hA never change `cfg`.
- R9: When `cfg[0]` is 1, a conversion ends after exactly 14 `sclk` rising edges counted after its start.
- R10: When `cfg[0]` is 0, a conversion ends after 14 ticks of an oscillator with one tick every OSC_DIV clocks. `int_n` falls between 13·OSC_DIV+2 and 14·OSC_DIV+1 clocks after the start edge.
- R11: `int_n` resets high, falls when a result is ready, and rises again on the next `cs_n` or `fs_n` falling edge.
- R12: `sdo_oe` is high only while `cs_n` is low. `sdo` carries {last result, 4'b0000} MSB first, with bit 15 valid at frame start and one shift per `sclk` falling edge.
- R13: After a frame with nibble 4'hC, the next frame's `sdo` carries {cfg, 4'b0000} in place of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| fs_n | input | 1 | Frame sync, falling edge starts a frame |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial command data in |
| cstart_n | input | 1 | External sampling control, tie high if unused |
| conv_data | input | 12 | Value the converter stand-in captures at conversion start |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` (low = high impedance) |
| int_n | output | 1 | Result-ready flag, active low |
| cfg | output | 12 | Configuration register |
| chan | output | 2 | Selected channel |
| sampling | output | 1 | Sample phase active |

## Verification
A wrong bit count shows at once in `cfg`: the 12 data bits land shifted or are not written at all, and the mismatch is visible the cycle after the frame closes. A wrong decode or a wrong mode flag shows as a `sampling` or `chan` change at the wrong edge. It can also show as an `int_n` fall that comes early, comes late or never comes, and this is visible within about fourteen conversion clocks. Output shifter faults show on the very next frame, as a wrong 16-bit word read back from `sdo`.

// File: rtl/acf_pkg.sv
`timescale 1ns/1ps
package acf_pkg;
  localparam int FRAME_W = 16;
  localparam int CMD_W   = 4;
  localparam int CFG_W   = 12;
  localparam int RES_W   = 12;
  localparam int CH_W    = 2;
  localparam logic [CMD_W-1:0] CMD_CFG_WR = 4'hA;
  localparam logic [CMD_W-1:0] CMD_CFG_RD = 4'hC;

  function automatic logic is_select(input logic [CMD_W-1:0] c);
    return c[CMD_W-1:CH_W] == '0;
  endfunction
endpackage

// File: rtl/acf_edge.sv
`timescale 1ns/1ps
module acf_edge #(
  parameter int N = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl <= RST_VAL;
    else        lvl <= din;
  end

  assign rise = din & ~lvl;
  assign fall = ~din & lvl;
endmodule

// File: rtl/acf_rx.sv
`timescale 1ns/1ps
module acf_rx import acf_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             start,
  input  logic             cs_rise,
  input  logic             sclk_rise,
  input  logic             sdi,
  output logic [CFG_W-1:0] cfg,
  output logic [CH_W-1:0]  chan,
  output logic             sel_pulse,
  output logic             frame_end,
  output logic             rd_req
);
  localparam int CW = $clog2(FRAME_W);

  logic             en;
  logic [CW-1:0]    cnt;
  logic [CFG_W-2:0] shreg;
  logic [CMD_W-1:0] cmd;
  logic             cmd_ok;
  logic [CFG_W-1:0] word;
  logic             take, last, nib, wr;

  assign word      = {shreg, sdi};
  assign take      = en & ~cs_n & sclk_rise;
  assign last      = take && (cnt == CW'(FRAME_W-1));
  assign nib       = take && (cnt == CW'(CMD_W-1));
  assign wr        = last && cmd_ok && (cmd == CMD_CFG_WR);
  assign rd_req    = last && cmd_ok && (cmd == CMD_CFG_RD);
  assign sel_pulse = nib && is_select(word[CMD_W-1:0]);
  assign frame_end = last | (en & cs_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
      cmd    <= '0;
      cmd_ok <= 1'b0;
      chan   <= '0;
    end else if (start) begin
      en     <= 1'b1;
      cnt    <= '0;
      cmd_ok <= 1'b0;
    end else if (cs_rise) begin
      en <= 1'b0;
    end else if (take) begin
      shreg <= word[CFG_W-2:0];
      cnt   <= cnt + 1'b1;
      if (last) en <= 1'b0;
      if (nib) begin
        cmd    <= word[CMD_W-1:0];
        cmd_ok <= 1'b1;
        if (is_select(word[CMD_W-1:0])) chan <= word[CH_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg <= '0;
    else if (wr) cfg <= word;
  end

  // R2: a closed frame neither counts nor shifts
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !start) |=> ($stable(cnt) && $stable(shreg)));
  // R3: an early chip-select rise closes the frame
  a_r3_cs_rise_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !start) |=> !en);
  // R8: the configuration moves only on a completed write frame
  a_r8_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cfg));
endmodule

// File: rtl/acf_conv.sv
`timescale 1ns/1ps
module acf_conv import acf_pkg::*; #(
  parameter int CONV_CLKS = 14,
  parameter int OSC_DIV   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             use_ext,
  input  logic             ext_tick,
  input  logic [RES_W-1:0] din,
  output logic             done,
  output logic [RES_W-1:0] result
);
  localparam int NW = $clog2(CONV_CLKS + 1);

  logic             osc_tick, tick, busy;
  logic [NW-1:0]    n;
  logic [RES_W-1:0] hold;

  generate
    if (OSC_DIV > 1) begin : g_div
      localparam int DW = $clog2(OSC_DIV);
      logic [DW-1:0] oc;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        oc <= '0;
        else if (oc == DW'(OSC_DIV - 1))   oc <= '0;
        else                               oc <= oc + 1'b1;
      end
      assign osc_tick = (oc == DW'(OSC_DIV - 1));
    end else begin : g_nodiv
      assign osc_tick = 1'b1;
    end
  endgenerate

  assign tick = use_ext ? ext_tick : osc_tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      n      <= '0;
      hold   <= '0;
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy <= 1'b1;
        n    <= '0;
        hold <= din;
      end else if (busy && tick) begin
        if (n == NW'(CONV_CLKS - 1)) begin
          busy   <= 1'b0;
          result <= hold;
          done   <= 1'b1;
        end else begin
          n <= n + 1'b1;
        end
      end
    end
  end

  // R9: the clock count never passes the latency
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (n < NW'(CONV_CLKS)));
  // R6: a start from idle always begins a conversion
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: rtl/acf_tx.sv
`timescale 1ns/1ps
module acf_tx import acf_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic             rd_req,
  input  logic [RES_W-1:0] result,
  input  logic [CFG_W-1:0] cfg,
  output logic             sdo
);
  logic [FRAME_W-1:0] sh;
  logic               rdsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      rdsel <= 1'b0;
    end else if (load) begin
      sh    <= rdsel ? {cfg, {(FRAME_W-CFG_W){1'b0}}}
                     : {result, {(FRAME_W-RES_W){1'b0}}};
      rdsel <= 1'b0;
    end else begin
      if (rd_req) rdsel <= 1'b1;
      if (shift)  sh <= {sh[FRAME_W-2:0], 1'b0};
    end
  end

  assign sdo = sh[FRAME_W-1];

  // R12: the output bit moves only on a load or a falling serial clock
  a_r12_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(sdo));
endmodule

// File: rtl/adc_cmd_frontend.sv
`timescale 1ns/1ps
module adc_cmd_frontend import acf_pkg::*; #(
  parameter int CONV_CLKS = 14,
  parameter int OSC_DIV   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             fs_n,
  input  logic             sclk,
  input  logic             sdi,
  input  logic             cstart_n,
  input  logic [RES_W-1:0] conv_data,
  output logic             sdo,
  output logic             sdo_oe,
  output logic             int_n,
  output logic [CFG_W-1:0] cfg,
  output logic [CH_W-1:0]  chan,
  output logic             sampling
);
  logic [3:0]       lvl, rise, fall;
  logic             sclk_rise, sclk_fall, cs_rise, frame_start, cst_rise, cst_lvl;
  logic             sel_pulse, frame_end, rd_req, done, norm_pend, conv_start;
  logic [RES_W-1:0] result;
  logic             unused_edges;

  acf_edge #(.N(4), .RST_VAL(4'b1110)) edge_i (
    .clk(clk), .rst_n(rst_n), .din({cstart_n, fs_n, cs_n, sclk}),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  assign sclk_rise    = rise[0];
  assign sclk_fall    = fall[0];
  assign cs_rise      = rise[1];
  assign frame_start  = fall[1] | fall[2];
  assign cst_rise     = rise[3];
  assign cst_lvl      = lvl[3];
  assign unused_edges = &{lvl[2:0], rise[2], fall[3]};

  acf_rx rx_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .start(frame_start),
    .cs_rise(cs_rise), .sclk_rise(sclk_rise), .sdi(sdi),
    .cfg(cfg), .chan(chan), .sel_pulse(sel_pulse),
    .frame_end(frame_end), .rd_req(rd_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     norm_pend <= 1'b0;
    else if (sel_pulse && cst_lvl)  norm_pend <= 1'b1;
    else if (frame_end)             norm_pend <= 1'b0;
  end

  assign conv_start = (norm_pend & frame_end) | cst_rise;
  assign sampling   = norm_pend | ~cst_lvl;

  acf_conv #(.CONV_CLKS(CONV_CLKS), .OSC_DIV(OSC_DIV)) conv_i (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .use_ext(cfg[0]),
    .ext_tick(sclk_rise), .din(conv_data), .done(done), .result(result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           int_n <= 1'b1;
    else if (done)        int_n <= 1'b0;
    else if (frame_start) int_n <= 1'b1;
  end

  acf_tx tx_i (
    .clk(clk), .rst_n(rst_n), .load(frame_start),
    .shift(sclk_fall & ~cs_n), .rd_req(rd_req),
    .result(result), .cfg(cfg), .sdo(sdo)
  );

  assign sdo_oe = ~cs_n;

  // R11: a finished conversion drops the flag
  a_r11_int_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !int_n);
  // R11: a new frame releases the flag
  a_r11_int_release: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !done) |=> int_n);
  // R7: with the start pin low, frame close launches nothing
  a_r7_ext_no_frame_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!cst_lvl && !cst_rise) |-> !conv_start);
endmodule

// File: tb/adc_cmd_frontend_tb_top.sv
`timescale 1ns/1ps
module adc_cmd_frontend_tb_top;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, fs_n, sclk, sdi, cstart_n;
  logic [11:0] conv_data;
  logic        sdo, sdo_oe, int_n, sampling;
  logic [11:0] cfg;
  logic [1:0]  chan;

  int vectors = 0;
  int miscompares = 0;
  logic       samp_log [0:31];
  logic [1:0] chan_log [0:31];
  logic [15:0] got;

  always #4 clk = ~clk;

  adc_cmd_frontend #(.CONV_CLKS(14), .OSC_DIV(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs_n(fs_n), .sclk(sclk), .sdi(sdi),
    .cstart_n(cstart_n), .conv_data(conv_data), .sdo(sdo), .sdo_oe(sdo_oe),
    .int_n(int_n), .cfg(cfg), .chan(chan), .sampling(sampling)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse();
    sclk = 1'b1; tick(2); sclk = 1'b0; tick(2);
  endtask

  task automatic do_frame(input logic [15:0] w, input int nbits, input bit via_fs,
                          output logic [15:0] rd);
    rd = '0;
    if (via_fs) begin fs_n = 1'b0; tick(1); fs_n = 1'b1; tick(1); end
    else begin cs_n = 1'b0; tick(2); end
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b1;
      if (i < 16) rd[15-i] = sdo;
      pulse();
      samp_log[i] = sampling;
      chan_log[i] = chan;
    end
    if (!via_fs) begin cs_n = 1'b1; tick(2); end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; fs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    cstart_n = 1'b1; conv_data = '0;
    tick(4); rst_n = 1'b1; tick(2);

    chk("R11 reset int_n", int_n, 1);
    chk("R12 reset sdo_oe", sdo_oe, 0);
    chk("R1 reset cfg", cfg, 0);
    chk("R5 reset sampling", sampling, 0);

    // R1: walking ones and mixed patterns through the write command
    for (int b = 0; b < 12; b++) begin
      do_frame({4'hA, 12'(1 << b)}, 16, 0, got);
      chk("R1 cfg write walk", cfg, 32'(1 << b));
    end
    do_frame(16'hAA5B, 16, 0, got); chk("R1 cfg write pattern", cfg, 12'hA5B);
    do_frame(16'hA5A4, 16, 0, got); chk("R1 cfg write pattern", cfg, 12'h5A4);

    // R12: output enable follows chip select
    cs_n = 1'b0; tick(2); chk("R12 oe low cs", sdo_oe, 1);
    cs_n = 1'b1; tick(2); chk("R12 oe high cs", sdo_oe, 0);

    // R8: every other nibble leaves the configuration alone
    for (int c = 0; c < 16; c++) begin
      if (c != 10) begin
        do_frame({4'(c), 12'hFFF}, 16, 0, got);
        chk("R8 non-write nibble", cfg, 12'h5A4);
      end
    end
    tick(200);

    // R2: bits after the 16th are dropped
    do_frame(16'hA122, 20, 0, got); chk("R2 extra edges ignored", cfg, 12'h122);

    // R4: frame-sync restarts with chip select held low
    cs_n = 1'b0; tick(2);
    do_frame(16'hA0F0, 16, 1, got); chk("R4 fs frame write", cfg, 12'h0F0);
    for (int i = 0; i < 16; i++) begin sdi = 1'b1; pulse(); end
    chk("R2 no restart without fs", cfg, 12'h0F0);
    do_frame(16'hA3C4, 16, 1, got); chk("R4 second fs frame", cfg, 12'h3C4);
    cs_n = 1'b1; tick(2);

    // R3: partial write aborted by chip select
    do_frame(16'hA7FE, 10, 0, got); chk("R3 partial write dropped", cfg, 12'h3C4);
    tick(200);

    // R5 R6 R10 R12: normal mode per channel
    for (int c = 0; c < 4; c++) begin
      conv_data = 12'(12'h0A5 + c * 12'h31B);
      do_frame({2'b00, 2'(c), 12'h000}, 16, 0, got);
      chk("R5 no sampling before nibble", samp_log[2], 0);
      chk("R5 sampling at 4th edge", samp_log[3], 1);
      chk("R5 channel select", chan_log[3], c);
      chk("R6 sampling ends at close", sampling, 0);
      tick(13*D - 6); chk("R10 int still high", int_n, 1);
      tick(D + 3);    chk("R10 int fell", int_n, 0);
      do_frame(16'hF000, 16, 0, got);
      chk("R12 sdo result word", got, {conv_data, 4'h0});
      chk("R11 int released by cs fall", int_n, 1);
    end

    // R6: early chip-select rise starts conversion
    conv_data = 12'hBEE;
    do_frame(16'h2000, 8, 0, got);
    tick(13*D - 2); chk("R6 early close int high", int_n, 1);
    tick(D + 3);    chk("R6 early close int fell", int_n, 0);
    do_frame(16'hF000, 16, 0, got); chk("R12 sdo after early close", got, 16'hBEE0);

    // R9: serial clock as conversion clock
    do_frame(16'hA001, 16, 0, got); chk("R9 clksrc set", cfg, 12'h001);
    conv_data = 12'h777;
    do_frame(16'h1000, 16, 0, got);
    for (int k = 0; k < 13; k++) pulse();
    chk("R9 int high after 13 edges", int_n, 1);
    pulse();
    chk("R9 int low after 14 edges", int_n, 0);
    do_frame(16'hF000, 16, 0, got); chk("R12 sdo sclk conversion", got, 16'h7770);
    do_frame(16'hA000, 16, 0, got);

    // R11: frame-sync fall releases int_n
    cs_n = 1'b0; tick(2);
    do_frame(16'h0000, 16, 1, got);
    tick(14*D + 10); chk("R11 int low before fs", int_n, 0);
    fs_n = 1'b0; tick(1); fs_n = 1'b1; tick(1);
    chk("R11 int released by fs fall", int_n, 1);
    cs_n = 1'b1; tick(2);

    // R7: external start pin
    conv_data = 12'h3C3;
    cstart_n = 1'b0; tick(2); chk("R7 sampling follows pin", sampling, 1);
    do_frame(16'h3000, 16, 0, got);
    chk("R7 channel in extended mode", chan, 3);
    tick(14*D + 10); chk("R7 no conversion at close", int_n, 1);
    chk("R7 still sampling", sampling, 1);
    cstart_n = 1'b1;
    tick(13*D); chk("R7 int high during conversion", int_n, 1);
    tick(D + 3); chk("R7 int fell after pin rise", int_n, 0);
    chk("R7 sampling ended", sampling, 0);
    do_frame(16'hF000, 16, 0, got); chk("R12 sdo extended result", got, 16'h3C30);

    // R13: configuration read-back
    do_frame(16'hA6B2, 16, 0, got);
    do_frame(16'hC000, 16, 0, got); chk("R13 read leaves cfg", cfg, 12'h6B2);
    do_frame(16'hF000, 16, 0, got); chk("R13 cfg on sdo", got, 16'h6B20);
    do_frame(16'hF000, 16, 0, got); chk("R13 result again", got, 16'h3C30);

    report();
    $finish;
  end
endmodule